// File: doc/BRIEF.md
# Colour Lookup Table with Sequenced Component Access

This block is a 260-entry colour lookup table for a display pipeline. Entries 0 to 255 are the pixel colours that an 8-bit pixel value selects. Entries 256 to 259 form a small overlay bank used for cursor colours. Each entry holds three 8-bit components: red, green and blue.

Software reaches the table through a 32-bit register bus with a valid, a write, an address and a four-lane byte enable. It first writes a table index. It then moves the colour components one at a time through a single data register. A phase counter selects the component, always in the order red, green, blue. After the blue component the phase returns to red and the index moves on by one. A second data offset reaches the overlay bank, using the low two bits of the same index.

A separate lookup port takes an entry number from the pixel pipeline. It returns the packed 24-bit colour one clock later.

Top module: `pal_clut`

## Requirements
- R1: After reset, every entry reads as black (000000), except entries 255, 256 and 258, which read as white (FFFFFF). After reset the index is 0 and the phase is red.
- R2: A write at offset 0 loads the index from data bits 31:24 and sets the phase to red.
- R3: Each data access at offset 4 or 12 advances the phase from red (0) to green (1) to blue (2). The access made during blue returns the phase to red and adds one to the index, modulo 256.
- R4: A write at offset 4 stores data bits 31:24 into the component, chosen by the phase, of pixel entry `index`.
- R5: A write at offset 12 stores data bits 31:24 into the component, chosen by the phase, of overlay entry 256 + index[1:0]. The index still steps over its full 8 bits.
- R6: A read at offset 4 or 12 returns the component chosen by the phase, for the same entry a write there would reach. The value appears on `bus_rdata` bits 31:24 during the cycle after the access, with bits 23:0 zero. In every other cycle `bus_rdata` is zero. The read steps the sequence exactly as a write does.
- R7: An access at any offset other than 0, 4 and 12, and a read at offset 0, changes no entry, no index and no phase.
- R8: An access whose byte enable is not 4'hF is ignored in full: no store, no sequence step, and zero read data.
- R9: `lk_rgb` shows {red, green, blue} of entry `lk_idx` one cycle after `lk_idx` is presented. An `lk_idx` of 260 or more gives zero.
- R10: A lookup presented in the same cycle as a component write to that entry returns the value the entry held before the write. The next lookup returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_be | input | 4 | Byte enables; only 4'hF is decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| lk_idx | input | 9 | Entry number for the display lookup |
| lk_rgb | output | 24 | Registered colour {R,G,B} of the looked-up entry |

## Verification
Register traffic and the display lookup can reach the same entry in the same clock. The clash that matters is a component store landing on the entry that the lookup port is reading. The bench sets the lookup index to the entry about to receive its blue component. It then checks that the colour returned after that edge is the old one, and that the next lookup shows the new one. A behavioural model runs beside the design, and a long mixed stretch keeps lookups running at random entries during register traffic. Any clash across the overlay and pixel banks is therefore compared cycle by cycle.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam int unsigned NUM_COMP = 3;

  // Entries that come out of reset white: last pixel entry, overlay 0 and overlay 2.
  function automatic logic is_white_default(input int unsigned ent, input int unsigned npix);
    return (ent == npix - 1) || (ent == npix) || (ent == npix + 2);
  endfunction

endpackage

// File: rtl/pal_seq.sv
module pal_seq #(
  parameter int unsigned IDX_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_en,
  input  logic [IDX_W-1:0]    load_val,
  input  logic                step_en,
  output logic [IDX_W-1:0]    idx_o,
  output pal_pkg::phase_e     phase_o
);
  import pal_pkg::*;

  logic [IDX_W-1:0] idx_q;
  phase_e           phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
    end else if (load_en) begin
      idx_q   <= load_val;
      phase_q <= PH_RED;
    end else if (step_en) begin
      case (phase_q)
        PH_RED:  phase_q <= PH_GRN;
        PH_GRN:  phase_q <= PH_BLU;
        default: begin
          phase_q <= PH_RED;
          idx_q   <= idx_q + 1'b1;
        end
      endcase
    end
  end

  assign idx_o   = idx_q;
  assign phase_o = phase_q;

  // R3: phase only ever takes the three component codes
  a_r3_phase_legal: assert property (@(posedge clk) disable iff (rst)
    phase_q inside {PH_RED, PH_GRN, PH_BLU});

  // R3: completing a triple wraps phase and bumps the index modulo 2^IDX_W
  a_r3_index_wrap: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en && phase_q == PH_BLU) |=>
      (idx_q == IDX_W'($past(idx_q) + 1'b1)) && (phase_q == PH_RED));

  // R2: index load takes the supplied value and restarts at red
  a_r2_index_load: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (idx_q == $past(load_val)) && (phase_q == PH_RED));

  // R7: without a load or a step the sequence state holds
  a_r7_seq_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !step_en) |=> $stable(idx_q) && $stable(phase_q));

endmodule

// File: rtl/pal_bank.sv
module pal_bank #(
  parameter int unsigned DEPTH = 260,
  parameter int unsigned NPIX  = 256,
  parameter int unsigned CW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [AW-1:0] a_addr,
  output logic [CW-1:0] a_data,
  input  logic [AW-1:0] b_addr,
  output logic [CW-1:0] b_data
);
  import pal_pkg::*;

  logic [CW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] touched;
  logic [CW-1:0]    a_comb, b_comb;

  // Storage array carries no reset so it can map onto RAM.
  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr < AW'(DEPTH)))
      mem[wr_addr] <= wr_data;
  end

  // One flag per entry marks whether the stored word replaces the reset colour.
  always_ff @(posedge clk) begin
    if (rst)
      touched <= '0;
    else if (wr_en && (wr_addr < AW'(DEPTH)))
      touched[wr_addr] <= 1'b1;
  end

  always_comb begin
    if (a_addr >= AW'(DEPTH))
      a_comb = '0;
    else if (touched[a_addr])
      a_comb = mem[a_addr];
    else
      a_comb = is_white_default(32'(a_addr), NPIX) ? '1 : '0;
  end

  always_comb begin
    if (b_addr >= AW'(DEPTH))
      b_comb = '0;
    else if (touched[b_addr])
      b_comb = mem[b_addr];
    else
      b_comb = is_white_default(32'(b_addr), NPIX) ? '1 : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_data <= '0;
      b_data <= '0;
    end else begin
      a_data <= a_comb;
      b_data <= b_comb;
    end
  end

  // R9: lookups beyond the table come back as zero
  a_r9_out_of_range: assert property (@(posedge clk) disable iff (rst)
    (b_addr >= AW'(DEPTH)) |=> (b_data == '0));

  // R10: a lookup of an untouched entry in the cycle it is first written yields its reset colour
  a_r10_old_value: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (b_addr == wr_addr) && (b_addr < AW'(DEPTH)) && !touched[b_addr]) |=>
      (b_data == (is_white_default(32'($past(b_addr)), NPIX) ? {CW{1'b1}} : {CW{1'b0}})));

endmodule

// File: rtl/pal_clut.sv
module pal_clut #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned NOVL   = 4,
  parameter int unsigned CW     = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DW     = 32
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   bus_valid,
  input  logic                                   bus_write,
  input  logic [ADDR_W-1:0]                      bus_addr,
  input  logic [DW/8-1:0]                        bus_be,
  input  logic [DW-1:0]                          bus_wdata,
  output logic [DW-1:0]                          bus_rdata,
  input  logic [$clog2((1<<IDX_W)+NOVL)-1:0]     lk_idx,
  output logic [3*CW-1:0]                        lk_rgb
);
  import pal_pkg::*;

  localparam int unsigned NPIX  = 1 << IDX_W;
  localparam int unsigned DEPTH = NPIX + NOVL;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned OVL_W = (NOVL > 1) ? $clog2(NOVL) : 1;
  localparam logic [ADDR_W-1:0] OFS_IDX = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_PIX = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_OVL = ADDR_W'(12);

  logic             acc_ok, hit_idx, hit_data, hit_rd, ovl_sel;
  logic [IDX_W-1:0] idx;
  phase_e           phase;
  logic [AW-1:0]    entry;
  logic [CW-1:0]    port_data [NUM_COMP];
  logic [CW-1:0]    lk_comp   [NUM_COMP];
  logic             rd_pend_q;
  phase_e           rd_comp_q;
  logic [CW-1:0]    rd_sel;

  assign acc_ok   = bus_valid && (bus_be == '1);
  assign hit_idx  = acc_ok && bus_write && (bus_addr == OFS_IDX);
  assign ovl_sel  = (bus_addr == OFS_OVL);
  assign hit_data = acc_ok && ((bus_addr == OFS_PIX) || ovl_sel);
  assign hit_rd   = hit_data && !bus_write;
  assign entry    = ovl_sel ? (AW'(NPIX) + AW'(idx[OVL_W-1:0])) : AW'(idx);

  pal_seq #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .load_en  (hit_idx),
    .load_val (bus_wdata[DW-1 -: IDX_W]),
    .step_en  (hit_data),
    .idx_o    (idx),
    .phase_o  (phase)
  );

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    pal_bank #(.DEPTH(DEPTH), .NPIX(NPIX), .CW(CW)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (hit_data && bus_write && (2'(phase) == 2'(c))),
      .wr_addr (entry),
      .wr_data (bus_wdata[DW-1 -: CW]),
      .a_addr  (entry),
      .a_data  (port_data[c]),
      .b_addr  (lk_idx),
      .b_data  (lk_comp[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend_q <= 1'b0;
      rd_comp_q <= PH_RED;
    end else begin
      rd_pend_q <= hit_rd;
      rd_comp_q <= phase;
    end
  end

  always_comb begin
    case (rd_comp_q)
      PH_RED:  rd_sel = port_data[0];
      PH_GRN:  rd_sel = port_data[1];
      default: rd_sel = port_data[2];
    endcase
  end

  assign bus_rdata = rd_pend_q ? {rd_sel, {(DW-CW){1'b0}}} : '0;
  assign lk_rgb    = {lk_comp[0], lk_comp[1], lk_comp[2]};

  // R8: partial-width accesses leave the sequence untouched
  a_r8_partial_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && (bus_be != '1)) |=> $stable(idx) && $stable(phase));

  // R7: offsets outside the decoded set leave the sequence untouched
  a_r7_other_offset: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && !hit_data && !hit_idx) |=> $stable(idx) && $stable(phase));

  // R6: read data is zero in any cycle that does not follow a data read
  a_r6_idle_rdata: assert property (@(posedge clk) disable iff (rst)
    !hit_rd |=> (bus_rdata == '0));

endmodule

// File: tb/pal_clut_tb.sv
`timescale 1ns/1ps
module pal_clut_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr  = '0;
  logic [3:0]  bus_be    = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [8:0]  lk_idx    = '0;
  logic [23:0] lk_rgb;

  always #4 clk = ~clk;

  pal_clut u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .lk_idx(lk_idx), .lk_rgb(lk_rgb)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  // Behavioural reference
  int          m_r [260];
  int          m_g [260];
  int          m_b [260];
  int          m_idx, m_ph;
  logic [31:0] e_rd;
  logic [23:0] e_lk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int comp_of(int e, int ph);
    if (ph == 0) return m_r[e];
    if (ph == 1) return m_g[e];
    return m_b[e];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < 260; e++) begin
        int v;
        v = (e == 255 || e == 256 || e == 258) ? 255 : 0;
        m_r[e] = v; m_g[e] = v; m_b[e] = v;
      end
      m_idx = 0; m_ph = 0; e_rd = '0; e_lk = '0;
    end else begin
      bit acc, dat;
      int ent;
      acc = bus_valid && (bus_be == 4'hF);
      dat = acc && (bus_addr == 4'd4 || bus_addr == 4'd12);
      ent = (bus_addr == 4'd12) ? 256 + (m_idx % 4) : m_idx;
      // lookup sees the table before this edge's store
      if (lk_idx < 260) e_lk = {8'(m_r[lk_idx]), 8'(m_g[lk_idx]), 8'(m_b[lk_idx])};
      else e_lk = '0;
      e_rd = (dat && !bus_write) ? {8'(comp_of(ent, m_ph)), 24'h0} : 32'h0;
      if (acc && bus_write && bus_addr == 4'd0) begin
        m_idx = int'(bus_wdata[31:24]); m_ph = 0;
      end else if (dat) begin
        if (bus_write) begin
          if (m_ph == 0) m_r[ent] = int'(bus_wdata[31:24]);
          else if (m_ph == 1) m_g[ent] = int'(bus_wdata[31:24]);
          else m_b[ent] = int'(bus_wdata[31:24]);
        end
        if (m_ph == 2) begin m_ph = 0; m_idx = (m_idx + 1) % 256; end
        else m_ph = m_ph + 1;
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(bus_rdata == e_rd, cur_req, "bus_rdata", bus_rdata, e_rd);
      chk(lk_rgb == e_lk, cur_req, "lk_rgb", {8'h0, lk_rgb}, {8'h0, e_lk});
    end
  end

  task automatic drive(input bit v, input bit w, input logic [3:0] a,
                       input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; bus_be = be;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    drive(1'b1, 1'b1, a, {v, 24'h5A5A5A}, 4'hF);
  endtask

  task automatic rd(input logic [3:0] a);
    drive(1'b1, 1'b0, a, 32'hDEAD_BEEF, 4'hF);
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 4'h0, 32'h0, 4'h0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset contents swept through lookup, and read back of entry 0
    cur_req = "R1";
    for (int e = 0; e < 262; e++) begin
      @(negedge clk); lk_idx = 9'(e);
    end
    rd(4'd4); rd(4'd4); rd(4'd4); idle();
    lk_idx = 9'd258; idle(); idle();
    chk(lk_rgb == 24'hFFFFFF, "R1", "entry 258 white", {8'h0, lk_rgb}, 32'h00FFFFFF);

    // R2, R4: load index, write a triple, look it up
    cur_req = "R2";
    wr(4'd0, 8'd5);
    cur_req = "R4";
    wr(4'd4, 8'h12); wr(4'd4, 8'h34); wr(4'd4, 8'h56); idle();
    lk_idx = 9'd5; idle(); idle();
    chk(lk_rgb == 24'h123456, "R4", "entry 5", {8'h0, lk_rgb}, 32'h00123456);

    // R6: read back through the data register
    cur_req = "R6";
    wr(4'd0, 8'd5); rd(4'd4); rd(4'd4); rd(4'd4); idle(); idle();

    // R3: wrap from 255 to 0
    cur_req = "R3";
    wr(4'd0, 8'd255);
    wr(4'd4, 8'hA1); wr(4'd4, 8'hA2); wr(4'd4, 8'hA3);
    wr(4'd4, 8'hB1); wr(4'd4, 8'hB2); wr(4'd4, 8'hB3); idle();
    lk_idx = 9'd0; idle(); idle();
    chk(lk_rgb == 24'hB1B2B3, "R3", "wrap to 0", {8'h0, lk_rgb}, 32'h00B1B2B3);

    // R5: overlay bank via low index bits
    cur_req = "R5";
    wr(4'd0, 8'h0E);
    wr(4'd12, 8'h01); wr(4'd12, 8'h02); wr(4'd12, 8'h03);
    wr(4'd12, 8'h04); idle();
    lk_idx = 9'd258; idle(); idle();
    chk(lk_rgb == 24'h010203, "R5", "overlay 258", {8'h0, lk_rgb}, 32'h00010203);
    wr(4'd0, 8'h0F); rd(4'd12); idle(); idle();

    // R7: other offsets and read of offset 0 touch nothing
    cur_req = "R7";
    wr(4'd0, 8'd9);
    wr(4'd8, 8'h77); wr(4'd2, 8'h77); rd(4'd0); rd(4'd8);
    wr(4'd4, 8'h11); wr(4'd4, 8'h22); wr(4'd4, 8'h33); idle();
    lk_idx = 9'd9; idle(); idle();
    chk(lk_rgb == 24'h112233, "R7", "entry 9", {8'h0, lk_rgb}, 32'h00112233);

    // R8: partial byte enables ignored
    cur_req = "R8";
    wr(4'd0, 8'd20);
    drive(1'b1, 1'b1, 4'd0, 32'h3000_0000, 4'h7);
    drive(1'b1, 1'b1, 4'd4, 32'hEE00_0000, 4'h8);
    drive(1'b1, 1'b0, 4'd4, 32'h0, 4'h1);
    wr(4'd4, 8'hC1); wr(4'd4, 8'hC2); wr(4'd4, 8'hC3); idle();
    lk_idx = 9'd20; idle(); idle();
    chk(lk_rgb == 24'hC1C2C3, "R8", "entry 20", {8'h0, lk_rgb}, 32'h00C1C2C3);

    // R9: out-of-range lookups
    cur_req = "R9";
    lk_idx = 9'd260; idle(); lk_idx = 9'd511; idle(); idle();
    chk(lk_rgb == 24'h0, "R9", "index 511", {8'h0, lk_rgb}, 32'h0);

    // R10: lookup collides with the blue store of the same entry
    cur_req = "R10";
    lk_idx = 9'd5;
    wr(4'd0, 8'd5); wr(4'd4, 8'h66); wr(4'd4, 8'h77);
    wr(4'd4, 8'h88); idle();
    chk(lk_rgb == 24'h667756, "R10", "old blue on collision", {8'h0, lk_rgb}, 32'h00667756);
    idle();
    chk(lk_rgb == 24'h667788, "R10", "new blue after", {8'h0, lk_rgb}, 32'h00667788);

    // Mixed traffic compared against the model every clock
    cur_req = "R6";
    for (int n = 0; n < 4000; n++) begin
      int sel;
      logic [3:0] a;
      sel = $urandom_range(0, 9);
      a = (sel < 1) ? 4'd0 : (sel < 5) ? 4'd4 : (sel < 8) ? 4'd12 : (sel < 9) ? 4'd8 : 4'd1;
      drive($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a,
            $urandom, ($urandom_range(0, 7) == 0) ? 4'hC : 4'hF);
      lk_idx = 9'($urandom_range(0, 270));
    end
    idle(); idle();
    finish_run();
  end

endmodule